// File: doc/BRIEF.md
# Video Line Edge Timestamp Capture

This block watches a one-bit binarized video signal together with the line-sync and field-sync pulses produced by an external sync separator. Instead of storing pixels, it keeps a sparse record of every level transition on each video line: when the binarized level changes, the current value of a free-running 16-bit timer is written into a small per-line slot buffer. A line therefore costs a handful of timestamps rather than a full row of samples. This keeps many lines per field within reach at fine horizontal resolution.

Clutter near the track border is skipped by opening each line's capture window late. The window opens once a delay has passed since line start. That delay comes from the dark-stripe centre measured on the line before: the midpoint of the first recorded falling edge and the next recorded rising edge, minus a configurable back-off. The first line of a field, and the first line after reset, use a configurable default delay. A low binarized level means dark and a high level means bright.

The block keeps its own line index, which restarts at every field sync. Each finished line announces itself on a one-cycle strobe that carries the line index, the number of stored records and an overflow flag. This summary is a valid-only stream. Video timing cannot wait, so there is no ready input: a host that needs the summary must take it in the cycle the strobe is high. Stored timestamps stay readable through a registered read port addressed by line and slot.

Top module: `edge_stamp_capture`

## Requirements
- R1: An internal 16-bit timer is cleared by reset and advances by one every clock. `vid_bin` passes through a two-stage synchronizer. An input change driven while the timer reads N is detected, and stored when accepted, with timestamp N+2.
- R2: Accepted transitions of both polarities are stored in slots 0, 1, 2 and so on, in arrival order. The number stored is reported as `done_count`.
- R3: The record limit is the smaller of `cfg_edge_lim` and SLOTS, sampled at line start. In-window transitions after the limit is reached are not stored. They raise `done_ovf` for that line and leave the stored slots unchanged.
- R4: An offset is the timer value minus the value latched at line start. A transition with offset below the current start delay is ignored. A transition with offset equal to or above it is accepted.
- R5: After reset, and after a field sync, the start delay is `cfg_start_dly` until a line has produced a centre.
- R6: The centre is (fall offset + rise offset) / 2, rounded down. It uses the first stored falling edge and the next stored rising edge. When a line closes with such a pair, `centre_pos` takes the centre and `centre_valid` goes to 1. The next line's start delay is then the centre minus `cfg_back_off`, floored at 0.
- R7: A line that closes without such a pair leaves `centre_pos` and `centre_valid` unchanged.
- R8: A `line_sync` pulse, or a `field_sync` pulse, closes the open line. This gives a one-cycle `line_done` in the following cycle, with the line's index, count and overflow flag.
- R9: A `field_sync` pulse clears the line index and the centre (`centre_valid` = 0). The next `line_sync` opens line 0 with no `line_done`.
- R10: Lines whose index is LINES or above are not captured and give no `line_done`. They also leave the centre unchanged.
- R11: `rd_stamp` shows, one cycle after the address is presented, the timestamp at (`rd_line`, `rd_slot`). It shows 0 when the line is LINES or above, or the slot is SLOTS or above.
- R12: During reset, `line_done` = 0, `centre_valid` = 0 and `rd_stamp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_bin | input | 1 | Binarized video, 1 = bright, 0 = dark (asynchronous) |
| line_sync | input | 1 | One-cycle pulse at each line start (synchronous) |
| field_sync | input | 1 | One-cycle pulse at each field start (synchronous) |
| cfg_start_dly | input | TS_W | Start delay used while no centre is known |
| cfg_back_off | input | TS_W | Amount subtracted from the previous centre |
| cfg_edge_lim | input | SLOT_W | Requested records per line |
| rd_line | input | LINE_W | Read address: line |
| rd_slot | input | SLOT_W | Read address: slot |
| rd_stamp | output | TS_W | Registered read data |
| line_done | output | 1 | One-cycle strobe for a finished line |
| done_line | output | LINE_W | Index of the finished line |
| done_count | output | SLOT_W | Records stored for that line |
| done_ovf | output | 1 | That line saw more edges than it could hold |
| centre_pos | output | TS_W | Current centre offset |
| centre_valid | output | 1 | Centre is known for this field |

## Verification
The bench builds the block with SLOTS=4 and LINES=3, keeping the 16-bit timestamp width. With four slots, a line filled to its limit and then overflowed takes only a few transitions. With three lines, the step past the last storable line, where capture and strobes stop, comes after three line syncs. Edge times are placed on exact offsets from line start, so the window boundary and the centre arithmetic are checked cycle-exactly.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_kind_e;

  // Level assumed on the video line while idle (bright background).
  localparam logic IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/esc_edge_sync.sv
module esc_edge_sync
  import esc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vid_in,
  output edge_kind_e edge_kind
);

  // pipe[0] is the first stage; pipe[STAGES] holds the previous synchronized sample
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= {(STAGES+1){IDLE_LEVEL}};
    else        pipe <= {pipe[STAGES-1:0], vid_in};
  end

  always_comb begin
    if (pipe[STAGES-1] == pipe[STAGES]) edge_kind = EDGE_NONE;
    else if (pipe[STAGES-1])            edge_kind = EDGE_RISE;
    else                                edge_kind = EDGE_FALL;
  end

  // R1: a rising report must come from a high sample one stage earlier
  p_rise_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_kind == EDGE_RISE) |-> $past(pipe[STAGES-2]));

  // R1: a falling report must come from a low sample one stage earlier
  p_fall_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_kind == EDGE_FALL) |-> !$past(pipe[STAGES-2]));

endmodule

// File: rtl/esc_line_ctl.sv
module esc_line_ctl
  import esc_pkg::*;
#(
  parameter  int TS_W   = 16,
  parameter  int SLOTS  = 10,
  parameter  int LINES  = 320,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int LINE_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse,
  input  logic              field_pulse,
  input  edge_kind_e        edge_kind,
  input  logic [TS_W-1:0]   now_ts,
  input  logic [TS_W-1:0]   cfg_dflt,
  input  logic [TS_W-1:0]   cfg_back,
  input  logic [SLOT_W-1:0] cfg_limit,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_line,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              done_vld,
  output logic [LINE_W-1:0] done_line,
  output logic [SLOT_W-1:0] done_cnt,
  output logic              done_ovf,
  output logic [TS_W-1:0]   centre,
  output logic              centre_ok
);

  logic              open_q;
  logic [LINE_W-1:0] idx_q;
  logic [LINE_W-1:0] idx_nx;
  logic [TS_W-1:0]   start_q;
  logic [TS_W-1:0]   fall_rel_q;
  logic [TS_W-1:0]   pair_c_q;
  logic              fall_seen_q;
  logic              pair_seen_q;
  logic              ovf_q;
  logic [SLOT_W-1:0] cnt_q;
  logic [SLOT_W-1:0] lim_q;
  logic [SLOT_W-1:0] eff_lim;

  logic [TS_W-1:0]   rel;
  logic [TS_W-1:0]   delay;
  logic [TS_W:0]     pair_sum;
  logic              in_win;
  logic              hit_in;
  logic              room;

  always_comb begin
    rel = now_ts - start_q;
    if (centre_ok) delay = (centre > cfg_back) ? (centre - cfg_back) : '0;
    else           delay = cfg_dflt;
    in_win   = open_q && (rel >= delay);
    hit_in   = (edge_kind != EDGE_NONE) && in_win && !line_pulse && !field_pulse;
    room     = cnt_q < lim_q;
    wr_en    = hit_in && room;
    wr_line  = idx_q;
    wr_slot  = cnt_q;
    pair_sum = {1'b0, fall_rel_q} + {1'b0, rel};
    eff_lim  = (int'(cfg_limit) > SLOTS) ? SLOT_W'(SLOTS) : cfg_limit;
    idx_nx   = open_q ? (idx_q + LINE_W'(1)) : idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      idx_q       <= '0;
      start_q     <= '0;
      fall_rel_q  <= '0;
      pair_c_q    <= '0;
      fall_seen_q <= 1'b0;
      pair_seen_q <= 1'b0;
      ovf_q       <= 1'b0;
      cnt_q       <= '0;
      lim_q       <= '0;
      centre      <= '0;
      centre_ok   <= 1'b0;
      done_vld    <= 1'b0;
      done_line   <= '0;
      done_cnt    <= '0;
      done_ovf    <= 1'b0;
    end else begin
      done_vld <= 1'b0;
      if (field_pulse) begin
        if (open_q) begin
          done_vld  <= 1'b1;
          done_line <= idx_q;
          done_cnt  <= cnt_q;
          done_ovf  <= ovf_q;
        end
        open_q    <= 1'b0;
        idx_q     <= '0;
        centre    <= '0;
        centre_ok <= 1'b0;
      end else if (line_pulse) begin
        if (open_q) begin
          done_vld  <= 1'b1;
          done_line <= idx_q;
          done_cnt  <= cnt_q;
          done_ovf  <= ovf_q;
          if (pair_seen_q) begin
            centre    <= pair_c_q;
            centre_ok <= 1'b1;
          end
        end
        idx_q       <= idx_nx;
        open_q      <= int'(idx_nx) < LINES;
        start_q     <= now_ts;
        cnt_q       <= '0;
        ovf_q       <= 1'b0;
        fall_seen_q <= 1'b0;
        pair_seen_q <= 1'b0;
        lim_q       <= eff_lim;
      end else begin
        if (wr_en) begin
          cnt_q <= cnt_q + SLOT_W'(1);
          if (edge_kind == EDGE_FALL && !fall_seen_q) begin
            fall_seen_q <= 1'b1;
            fall_rel_q  <= rel;
          end
          if (edge_kind == EDGE_RISE && fall_seen_q && !pair_seen_q) begin
            pair_seen_q <= 1'b1;
            pair_c_q    <= TS_W'(pair_sum >> 1);
          end
        end
        if (hit_in && !room) ovf_q <= 1'b1;
      end
    end
  end

  // R3: stored count never passes the limit latched at line start
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R3: overflow only once the line is full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == lim_q));

  // R9: a field pulse leaves the index at zero and the centre unknown
  p_field_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(field_pulse) |-> (idx_q == '0 && !centre_ok));

  // R10: writes only target storable lines
  p_wr_line_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_line) < LINES));

  // R8: a reported line never claims more records than slots exist
  p_done_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> (int'(done_cnt) <= SLOTS));

endmodule

// File: rtl/esc_stamp_store.sv
module esc_stamp_store #(
  parameter  int TS_W   = 16,
  parameter  int SLOTS  = 10,
  parameter  int LINES  = 320,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int LINE_W = $clog2(LINES + 1),
  localparam int DEPTH  = LINES * SLOTS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [TS_W-1:0]   wr_data,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [TS_W-1:0]   rd_data
);

  logic [TS_W-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic              rd_ok;

  always_comb begin
    waddr = ADDR_W'(int'(wr_line) * SLOTS + int'(wr_slot));
    raddr = ADDR_W'(int'(rd_line) * SLOTS + int'(rd_slot));
    rd_ok = (int'(rd_line) < LINES) && (int'(rd_slot) < SLOTS);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= mem[raddr];
    else            rd_data <= '0;
  end

  // R3: a write never lands past the last slot of a line
  p_wr_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < SLOTS));

  // R11: out-of-range addresses read back as zero
  p_oob_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_line) >= LINES) |=> (rd_data == '0));

endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import esc_pkg::*;
#(
  parameter  int TS_W        = 16,
  parameter  int SLOTS       = 10,
  parameter  int LINES       = 320,
  parameter  int SYNC_STAGES = 2,
  localparam int SLOT_W      = $clog2(SLOTS + 1),
  localparam int LINE_W      = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_bin,
  input  logic              line_sync,
  input  logic              field_sync,
  input  logic [TS_W-1:0]   cfg_start_dly,
  input  logic [TS_W-1:0]   cfg_back_off,
  input  logic [SLOT_W-1:0] cfg_edge_lim,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [TS_W-1:0]   rd_stamp,
  output logic              line_done,
  output logic [LINE_W-1:0] done_line,
  output logic [SLOT_W-1:0] done_count,
  output logic              done_ovf,
  output logic [TS_W-1:0]   centre_pos,
  output logic              centre_valid
);

  logic [TS_W-1:0]   timer_q;
  edge_kind_e        kind;
  logic              wr_en;
  logic [LINE_W-1:0] wr_line;
  logic [SLOT_W-1:0] wr_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) timer_q <= '0;
    else        timer_q <= timer_q + TS_W'(1);
  end

  // R1: the timestamp source advances by exactly one per clock
  p_timer_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (timer_q == $past(timer_q) + TS_W'(1)));

  esc_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .vid_in    (vid_bin),
    .edge_kind (kind)
  );

  esc_line_ctl #(
    .TS_W  (TS_W),
    .SLOTS (SLOTS),
    .LINES (LINES)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_pulse  (line_sync),
    .field_pulse (field_sync),
    .edge_kind   (kind),
    .now_ts      (timer_q),
    .cfg_dflt    (cfg_start_dly),
    .cfg_back    (cfg_back_off),
    .cfg_limit   (cfg_edge_lim),
    .wr_en       (wr_en),
    .wr_line     (wr_line),
    .wr_slot     (wr_slot),
    .done_vld    (line_done),
    .done_line   (done_line),
    .done_cnt    (done_count),
    .done_ovf    (done_ovf),
    .centre      (centre_pos),
    .centre_ok   (centre_valid)
  );

  esc_stamp_store #(
    .TS_W  (TS_W),
    .SLOTS (SLOTS),
    .LINES (LINES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_line (wr_line),
    .wr_slot (wr_slot),
    .wr_data (timer_q),
    .rd_line (rd_line),
    .rd_slot (rd_slot),
    .rd_data (rd_stamp)
  );

endmodule

// File: tb/test_edge_stamp_capture.sv
module test_edge_stamp_capture;

  localparam int TS_W   = 16;
  localparam int SLOTS  = 4;
  localparam int LINES  = 3;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int LINE_W = $clog2(LINES + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vid = 1'b1;
  logic              hs = 1'b0;
  logic              vs = 1'b0;
  logic [TS_W-1:0]   cfg_dly = 16'd20;
  logic [TS_W-1:0]   cfg_back = 16'd5;
  logic [SLOT_W-1:0] cfg_lim = SLOT_W'(4);
  logic [LINE_W-1:0] rd_line = '0;
  logic [SLOT_W-1:0] rd_slot = '0;
  logic [TS_W-1:0]   rd_stamp;
  logic              line_done;
  logic [LINE_W-1:0] done_line;
  logic [SLOT_W-1:0] done_count;
  logic              done_ovf;
  logic [TS_W-1:0]   centre_pos;
  logic              centre_valid;

  always #10 clk = ~clk;

  edge_stamp_capture #(
    .TS_W  (TS_W),
    .SLOTS (SLOTS),
    .LINES (LINES)
  ) i_edge_stamp_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .vid_bin       (vid),
    .line_sync     (hs),
    .field_sync    (vs),
    .cfg_start_dly (cfg_dly),
    .cfg_back_off  (cfg_back),
    .cfg_edge_lim  (cfg_lim),
    .rd_line       (rd_line),
    .rd_slot       (rd_slot),
    .rd_stamp      (rd_stamp),
    .line_done     (line_done),
    .done_line     (done_line),
    .done_count    (done_count),
    .done_ovf      (done_ovf),
    .centre_pos    (centre_pos),
    .centre_valid  (centre_valid)
  );

  // Reference model of the free-running count (R1): clears in reset, +1 per clock.
  logic [TS_W-1:0] bench_t;
  always_ff @(posedge clk) begin
    if (!rst_n) bench_t <= '0;
    else        bench_t <= bench_t + 16'd1;
  end

  int checks = 0;
  int fails  = 0;
  int start  = 0;
  int lv, lidx, lcnt, lovf;
  int s0, s1, s2, s5;
  int v;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic grab();
    lv   = int'(line_done);
    lidx = int'(done_line);
    lcnt = int'(done_count);
    lovf = int'(done_ovf);
  endtask

  task automatic open_line();
    repeat (4) @(negedge clk);
    start = int'(bench_t);
    hs = 1'b1;
    @(negedge clk);
    grab();
    hs = 1'b0;
  endtask

  task automatic field_pulse();
    repeat (4) @(negedge clk);
    vs = 1'b1;
    @(negedge clk);
    grab();
    vs = 1'b0;
  endtask

  task automatic edge_at(input int rel, input logic lvl);
    while (int'(bench_t) + 2 - start != rel) @(negedge clk);
    vid = lvl;
  endtask

  task automatic rd(input int l, input int s, output int val);
    @(negedge clk);
    rd_line = LINE_W'(l);
    rd_slot = SLOT_W'(s);
    @(negedge clk);
    val = int'(rd_stamp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12", "line_done in reset", int'(line_done), 0);
    chk("R12", "centre_valid in reset", int'(centre_valid), 0);
    chk("R12", "rd_stamp in reset", int'(rd_stamp), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_line();
    field_pulse();
    chk("R9", "no strobe without open line", lv, 0);
    open_line();
    s0 = start;
    chk("R9", "first open gives no strobe", lv, 0);
    edge_at(30, 1'b0);
    edge_at(46, 1'b1);
    open_line();
    s1 = start;
    chk("R8", "line 0 strobe", lv, 1);
    chk("R8", "line 0 index", lidx, 0);
    chk("R2", "line 0 count", lcnt, 2);
    chk("R8", "line 0 overflow", lovf, 0);
    chk("R6", "centre after line 0", int'(centre_pos), 38);
    chk("R6", "centre valid", int'(centre_valid), 1);
    rd(0, 0, v); chk("R1", "line 0 slot 0 stamp", v, s0 + 30);
    rd(0, 1, v); chk("R2", "line 0 slot 1 stamp", v, s0 + 46);
  endtask

  task automatic t_window();
    // delay now 38-5 = 33
    edge_at(32, 1'b0);
    edge_at(33, 1'b1);
    edge_at(50, 1'b0);
    edge_at(70, 1'b1);
    cfg_lim = SLOT_W'(2);
    open_line();
    s2 = start;
    cfg_lim = SLOT_W'(4);
    chk("R8", "line 1 index", lidx, 1);
    chk("R4", "line 1 count excludes early edge", lcnt, 3);
    chk("R6", "centre after line 1", int'(centre_pos), 60);
    rd(1, 0, v); chk("R4", "boundary edge stored in slot 0", v, s1 + 33);
    rd(1, 2, v); chk("R2", "line 1 slot 2 stamp", v, s1 + 70);
  endtask

  task automatic t_overflow();
    // delay 55, limit latched as 2
    edge_at(60, 1'b0);
    edge_at(64, 1'b1);
    edge_at(80, 1'b0);
    edge_at(90, 1'b1);
    open_line();
    chk("R8", "line 2 strobe", lv, 1);
    chk("R3", "line 2 count at limit", lcnt, 2);
    chk("R3", "line 2 overflow flag", lovf, 1);
    chk("R6", "centre after line 2", int'(centre_pos), 62);
    rd(2, 1, v); chk("R3", "line 2 slot 1 stamp", v, s2 + 64);
  endtask

  task automatic t_past_last();
    edge_at(70, 1'b0);
    edge_at(90, 1'b1);
    open_line();
    chk("R10", "no strobe past last line", lv, 0);
    chk("R10", "centre unchanged past last line", int'(centre_pos), 62);
    rd(2, 0, v); chk("R3", "line 2 slot 0 untouched", v, s2 + 60);
    rd(2, 1, v); chk("R3", "line 2 slot 1 untouched", v, s2 + 64);
  endtask

  task automatic t_new_field();
    field_pulse();
    chk("R9", "no strobe when no line open", lv, 0);
    chk("R9", "centre cleared", int'(centre_valid), 0);
    open_line();
    s5 = start;
    chk("R9", "reopen gives no strobe", lv, 0);
    edge_at(19, 1'b0);
    edge_at(20, 1'b1);
    edge_at(40, 1'b0);
    edge_at(56, 1'b1);
    open_line();
    chk("R9", "index restarts at 0", lidx, 0);
    chk("R5", "default delay boundary count", lcnt, 3);
    chk("R6", "centre in new field", int'(centre_pos), 48);
    rd(0, 0, v); chk("R5", "first accepted at default delay", v, s5 + 20);
    rd(0, 2, v); chk("R2", "slot 2 in new field", v, s5 + 56);
  endtask

  task automatic t_no_pair();
    edge_at(50, 1'b0);
    open_line();
    chk("R8", "line 1 strobe", lv, 1);
    chk("R2", "single edge count", lcnt, 1);
    chk("R7", "centre kept without pair", int'(centre_pos), 48);
    chk("R7", "centre still valid", int'(centre_valid), 1);
    edge_at(60, 1'b1);
    field_pulse();
    chk("R8", "field closes open line", lv, 1);
    chk("R8", "field-closed index", lidx, 2);
    chk("R8", "field-closed count", lcnt, 1);
    chk("R9", "centre cleared by field", int'(centre_valid), 0);
    open_line();
    open_line();
    chk("R9", "fresh field line index", lidx, 0);
    chk("R9", "fresh field line empty", lcnt, 0);
  endtask

  task automatic t_read_range();
    rd(3, 0, v); chk("R11", "line out of range reads 0", v, 0);
    rd(0, 4, v); chk("R11", "slot out of range reads 0", v, 0);
    rd(1, 1, v); chk("R11", "in-range read after bad ones", v, s1 + 50);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_line();
    t_window();
    t_overflow();
    t_past_last();
    t_new_field();
    t_no_pair();
    t_read_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule